// File: doc/BRIEF.md
# Programmable Interrupt Controller Command Unit

This block is the register and command side of an eight-line interrupt controller. It sits beside a separate request latch and a priority resolver. Software reaches it through a byte-wide port with a single address bit. The unit keeps the interrupt mask, the in-service bits, the vector base, the rotating priority base and the mode flags, and it feeds that state back to the resolver. The resolver supplies the line that currently wins arbitration.

Software first programs the unit with a short sequence of initialization words. After that, command words on address 0 retire in-service lines, move the priority base, arm polling, choose the read source and set special mask mode. When the processor acknowledges an interrupt, the unit marks the winning line as in service and drives the vector number. In automatic end-of-interrupt mode the line is retired at once, and the priority base can rotate past it. A read with poll armed returns the winning line instead of a register and retires that line.

Top module: `pic_cmd_unit`

## Requirements
- R1: After reset, the mask, in-service bits, vector base, priority base, poll, read select, special mask, special nesting, automatic end-of-interrupt and rotate-on-automatic-end-of-interrupt are all zero. The unit is in normal operation, so an address-1 write loads the mask.
- R2: A write to address 0 with data bit 4 set starts initialization. It clears the mask, the priority base, special mask and read select, and it records data bit 0 as "mode word follows". When bit 0 is 0, it also clears special nesting and automatic end-of-interrupt.
- R3: During initialization, the first address-1 write stores data AND 0xF8 as the vector base and leaves the mask unchanged. The second address-1 write is ignored. After it, the unit goes to the mode word if one was requested, or else to normal operation.
- R4: The mode word (third address-1 write, only when requested) sets special nesting from data bit 4 and automatic end-of-interrupt from data bit 1, then returns to normal operation.
- R5: In normal operation an address-1 write loads the mask. An address-1 read without poll returns the mask.
- R6: An address-0 write with bit 4 clear and bit 3 set is a control word. Bit 2 arms poll. When bit 1 is set, bit 0 selects the address-0 read source (1 = in-service, 0 = request input). When bit 6 is set, bit 5 becomes special mask. Other fields leave these unchanged.
- R7: Command code 1 (data bits 7:5 of an address-0 write with bits 4 and 3 clear) clears the highest-priority in-service bit. Priority order starts at the priority base and rises modulo 8. Code 5 does the same and also sets the priority base to that line + 1. With no bit in service, neither code changes anything.
- R8: Code 3 clears in-service bit data[2:0]. Code 7 does the same and sets the priority base to data[2:0] + 1. Code 6 sets the priority base to data[2:0] + 1 mod 8. Code 2 changes nothing.
- R9: Codes 0 and 4 set rotate-on-automatic-end-of-interrupt to data bit 7.
- R10: During acknowledge, the vector output is the vector base + the winning line, or base + 7 when no line wins. Without automatic end-of-interrupt, the winning line's in-service bit is set at the clock edge. With no winner, no state changes.
- R11: With automatic end-of-interrupt, acknowledge leaves the in-service bits unchanged. If rotate-on-automatic-end-of-interrupt is set, the priority base becomes winning line + 1.
- R12: A read with poll armed returns the winning line (7 when none) and disarms poll. With a winner, it clears that in-service bit and pulses a one-hot request-clear output for the line during the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| ack | input | 1 | Interrupt acknowledge strobe |
| irr | input | LINES | Request bits from the request latch |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | LW | Winning line number |
| rdata | output | DATA_W | Read data, combinational |
| vector | output | DATA_W | Vector number, combinational |
| irr_clr | output | LINES | One-hot request clear during a poll read |
| imr | output | LINES | Mask register |
| isr | output | LINES | In-service bits |
| prio_base | output | LW | Line with highest priority |
| spec_mask | output | 1 | Special mask mode |
| spec_nest | output | 1 | Special nesting mode |

## Verification
The assertions assume that write, read and acknowledge are never raised in the same cycle, and that the winning line is only used while it is flagged valid. The in-service and priority-base checks rely on both. The bench drives exactly one strobe per cycle from its vector table and its directed tasks. It changes the resolver inputs only together with the strobe they belong to, so every property sees one operation at a time.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [1:0] {
      INIT_NORMAL = 2'd0,
      INIT_BASE   = 2'd1,
      INIT_SKIP   = 2'd2,
      INIT_MODE   = 2'd3
   } init_st_t;

   localparam logic [2:0] CMD_ROT_A  = 3'd0;
   localparam logic [2:0] CMD_EOI_HI = 3'd1;
   localparam logic [2:0] CMD_NOP    = 3'd2;
   localparam logic [2:0] CMD_EOI_LN = 3'd3;
   localparam logic [2:0] CMD_ROT_B  = 3'd4;
   localparam logic [2:0] CMD_REOI_H = 3'd5;
   localparam logic [2:0] CMD_SETPRI = 3'd6;
   localparam logic [2:0] CMD_REOI_L = 3'd7;

   typedef struct packed {
      logic ctl_word;     // poll / read-select / special-mask word
      logic rot_aeoi_wr;  // load rotate-on-auto-EOI flag
      logic eoi_top;      // retire highest-priority in-service line
      logic eoi_given;    // retire the line named in the data
      logic rot_after;    // move priority base past the retired line
      logic base_load;    // set priority base directly
   } pic_ops_t;

endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
   parameter int LINES = 8,
   parameter int LW    = $clog2(LINES)
) (
   input  logic [LINES-1:0] bits_in,
   input  logic [LW-1:0]    rot_base,
   output logic             hit,
   output logic [LW-1:0]    line
);
   logic [LINES-1:0] rot;
   logic [LW-1:0]    off;

   for (genvar k = 0; k < LINES; k++) begin : g_rot
      logic [LW-1:0] idx;
      assign idx    = rot_base + LW'(k);
      assign rot[k] = bits_in[idx];
   end

   always_comb begin
      off = '0;
      for (int k = LINES - 1; k >= 0; k--) begin
         if (rot[k]) off = LW'(k);
      end
   end

   assign hit  = |rot;
   assign line = rot_base + off;
endmodule

// File: rtl/pic_ocw_decode.sv
module pic_ocw_decode
   import pic_pkg::*;
(
   input  logic       wr0,
   input  logic [4:0] cmd_bits,   // data bits 7:3
   output pic_ops_t   ops
);
   logic [2:0] code;
   assign code = cmd_bits[4:2];

   always_comb begin
      ops = '0;
      if (wr0 && !cmd_bits[1]) begin
         if (cmd_bits[0]) begin
            ops.ctl_word = 1'b1;
         end else begin
            unique case (code)
               CMD_ROT_A, CMD_ROT_B: ops.rot_aeoi_wr = 1'b1;
               CMD_EOI_HI:           ops.eoi_top     = 1'b1;
               CMD_REOI_H: begin
                  ops.eoi_top   = 1'b1;
                  ops.rot_after = 1'b1;
               end
               CMD_EOI_LN:           ops.eoi_given   = 1'b1;
               CMD_REOI_L: begin
                  ops.eoi_given = 1'b1;
                  ops.rot_after = 1'b1;
               end
               CMD_SETPRI:           ops.base_load   = 1'b1;
               CMD_NOP:              ;
               default:              ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] wdata,
   output init_st_t          st,
   output logic [DATA_W-1:0] vbase,
   output logic              spec_nest,
   output logic              aeoi,
   output logic              mask_load
);
   localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'(LINES - 1);

   logic need_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= INIT_NORMAL;
         need_mode <= 1'b0;
         vbase     <= '0;
         spec_nest <= 1'b0;
         aeoi      <= 1'b0;
      end else if (start_wr) begin
         need_mode <= wdata[0];
         st        <= INIT_BASE;
         if (!wdata[0]) begin
            spec_nest <= 1'b0;
            aeoi      <= 1'b0;
         end
      end else if (cfg_wr) begin
         unique case (st)
            INIT_BASE: begin
               vbase <= wdata & BASE_MASK;
               st    <= INIT_SKIP;
            end
            INIT_SKIP: st <= need_mode ? INIT_MODE : INIT_NORMAL;
            INIT_MODE: begin
               spec_nest <= wdata[4];
               aeoi      <= wdata[1];
               st        <= INIT_NORMAL;
            end
            default: ;
         endcase
      end
   end

   assign mask_load = cfg_wr && (st == INIT_NORMAL);

   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !start_wr && st == INIT_BASE) |=> (vbase == ($past(wdata) & BASE_MASK))); // R3
   AST_SKIP_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (st != INIT_NORMAL) |-> !mask_load); // R3
   AST_MODE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !start_wr && st == INIT_MODE) |=> (st == INIT_NORMAL)); // R4
endmodule

// File: rtl/pic_cmd_unit.sv
module pic_cmd_unit
   import pic_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINES  = 8,
   parameter int LW     = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              ack,
   input  logic [LINES-1:0]  irr,
   input  logic              win_valid,
   input  logic [LW-1:0]     win_line,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] vector,
   output logic [LINES-1:0]  irr_clr,
   output logic [LINES-1:0]  imr,
   output logic [LINES-1:0]  isr,
   output logic [LW-1:0]     prio_base,
   output logic              spec_mask,
   output logic              spec_nest
);
   localparam logic [LW-1:0] SPUR_LINE = LW'(LINES - 1);

   if ((LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (DATA_W < 8 || DATA_W < LINES) begin : g_bad_width
      $error("DATA_W must be at least 8 and at least LINES");
   end
   if (LW != $clog2(LINES)) begin : g_bad_lw
      $error("LW must equal clog2(LINES)");
   end

   logic                  wr0, wr1, icw_start;
   init_st_t              init_st;
   logic [DATA_W-1:0]     vbase;
   logic                  aeoi, mask_load;
   pic_ops_t              ops;
   logic                  top_hit;
   logic [LW-1:0]         top_line;
   logic [LW-1:0]         cmd_line;
   logic                  poll, rsel, rot_aeoi;
   logic [LINES-1:0]      isr_n;
   logic [LW-1:0]         base_n;
   logic [LW-1:0]         rep_line;
   logic                  poll_take;

   assign wr0       = wr_en && !addr;
   assign wr1       = wr_en && addr;
   assign icw_start = wr0 && wdata[4];
   assign cmd_line  = wdata[LW-1:0];
   assign rep_line  = win_valid ? win_line : SPUR_LINE;
   assign poll_take = rd_en && poll && win_valid;

   pic_init_seq #(.DATA_W(DATA_W), .LINES(LINES)) u_init (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_wr  (icw_start),
      .cfg_wr    (wr1),
      .wdata     (wdata),
      .st        (init_st),
      .vbase     (vbase),
      .spec_nest (spec_nest),
      .aeoi      (aeoi),
      .mask_load (mask_load)
   );

   pic_ocw_decode u_dec (
      .wr0      (wr0),
      .cmd_bits (wdata[7:3]),
      .ops      (ops)
   );

   pic_prio_find #(.LINES(LINES), .LW(LW)) u_top (
      .bits_in  (isr),
      .rot_base (prio_base),
      .hit      (top_hit),
      .line     (top_line)
   );

   always_comb begin
      isr_n  = isr;
      base_n = prio_base;
      if (ops.eoi_top && top_hit) begin
         isr_n[top_line] = 1'b0;
         if (ops.rot_after) base_n = top_line + LW'(1);
      end
      if (ops.eoi_given) begin
         isr_n[cmd_line] = 1'b0;
         if (ops.rot_after) base_n = cmd_line + LW'(1);
      end
      if (ops.base_load) base_n = cmd_line + LW'(1);
      if (icw_start)     base_n = '0;
      if (ack && win_valid) begin
         if (!aeoi)         isr_n[win_line] = 1'b1;
         else if (rot_aeoi) base_n = win_line + LW'(1);
      end
      if (poll_take) isr_n[win_line] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr       <= '0;
         isr       <= '0;
         prio_base <= '0;
         poll      <= 1'b0;
         rsel      <= 1'b0;
         spec_mask <= 1'b0;
         rot_aeoi  <= 1'b0;
      end else begin
         isr       <= isr_n;
         prio_base <= base_n;
         if (icw_start) begin
            imr       <= '0;
            spec_mask <= 1'b0;
            rsel      <= 1'b0;
         end
         if (mask_load) imr <= wdata[LINES-1:0];
         if (ops.ctl_word) begin
            if (wdata[2]) poll      <= 1'b1;
            if (wdata[1]) rsel      <= wdata[0];
            if (wdata[6]) spec_mask <= wdata[5];
         end
         if (ops.rot_aeoi_wr) rot_aeoi <= wdata[7];
         if (rd_en && poll)   poll     <= 1'b0;
      end
   end

   always_comb begin
      if (poll)      rdata = DATA_W'(rep_line);
      else if (addr) rdata = DATA_W'(imr);
      else if (rsel) rdata = DATA_W'(isr);
      else           rdata = DATA_W'(irr);
   end

   assign vector  = vbase | DATA_W'(rep_line);
   assign irr_clr = poll_take ? (LINES'(1) << win_line) : '0;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, rd_en, ack})); // R10
   AST_ICW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      icw_start |=> (imr == '0 && prio_base == '0 && !spec_mask)); // R2
   AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && win_valid && !aeoi && !wr_en && !rd_en) |=> isr[$past(win_line)]); // R10
   AST_AEOI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && aeoi && !wr_en && !rd_en) |=> (isr == $past(isr))); // R11
   AST_POLL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && poll && !wr_en) |=> !poll); // R12
   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irr_clr)); // R12
   AST_CLR_ONLY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (irr_clr != '0) |=> !isr[$past(win_line)]); // R12
endmodule

// File: tb/pic_cmd_unit_test.sv
module pic_cmd_unit_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       addr, wr_en, rd_en, ack, win_valid;
   logic [7:0] wdata, irr;
   logic [2:0] win_line;
   logic [7:0] rdata, vector, irr_clr, imr, isr;
   logic [2:0] prio_base;
   logic       spec_mask, spec_nest;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pic_cmd_unit uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .ack(ack), .irr(irr), .win_valid(win_valid),
      .win_line(win_line), .rdata(rdata), .vector(vector), .irr_clr(irr_clr),
      .imr(imr), .isr(isr), .prio_base(prio_base), .spec_mask(spec_mask),
      .spec_nest(spec_nest)
   );

   // op: 0 write, 1 read, 2 ack, 3 idle
   // check: 0 none, 1 rdata, 2 vector, 3 isr, 4 imr, 5 base, 6 nest, 7 smask
   // layout: op[29:28] a[27] d[26:19] wv[18] wl[17:15] ck[14:12] ex[11:4] rq[3:0]
   localparam int N = 59;
   localparam logic [29:0] TBL [N] = '{
      {2'd0,1'b0,8'h11,1'b0,3'd0,3'd0,8'h00,4'd2},   // R2 start, mode word follows
      {2'd0,1'b1,8'h48,1'b0,3'd0,3'd4,8'h00,4'd3},   // R3 base word
      {2'd0,1'b1,8'h00,1'b0,3'd0,3'd4,8'h00,4'd3},   // R3 ignored word
      {2'd0,1'b1,8'h10,1'b0,3'd0,3'd6,8'h01,4'd4},   // R4 nesting on
      {2'd0,1'b1,8'hF0,1'b0,3'd0,3'd4,8'hF0,4'd5},   // R5 mask
      {2'd1,1'b1,8'h00,1'b0,3'd0,3'd1,8'hF0,4'd5},   // R5 read mask
      {2'd2,1'b0,8'h00,1'b1,3'd3,3'd2,8'h4B,4'd10},  // R10
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h08,4'd10},
      {2'd2,1'b0,8'h00,1'b1,3'd5,3'd2,8'h4D,4'd10},
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h28,4'd10},
      {2'd0,1'b0,8'h20,1'b0,3'd0,3'd3,8'h20,4'd7},   // R7 code 1
      {2'd0,1'b0,8'h0B,1'b0,3'd0,3'd0,8'h00,4'd6},   // R6 select isr
      {2'd1,1'b0,8'h00,1'b0,3'd0,3'd1,8'h20,4'd6},
      {2'd0,1'b0,8'h0A,1'b0,3'd0,3'd0,8'h00,4'd6},   // R6 select irr
      {2'd1,1'b0,8'h00,1'b0,3'd0,3'd1,8'hA5,4'd6},
      {2'd0,1'b0,8'h65,1'b0,3'd0,3'd3,8'h00,4'd8},   // R8 code 3 line 5
      {2'd2,1'b0,8'h00,1'b0,3'd0,3'd2,8'h4F,4'd10},  // R10 spurious
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h00,4'd10},
      {2'd0,1'b0,8'hC2,1'b0,3'd0,3'd5,8'h03,4'd8},   // R8 code 6
      {2'd2,1'b0,8'h00,1'b1,3'd1,3'd0,8'h00,4'd10},
      {2'd2,1'b0,8'h00,1'b1,3'd4,3'd2,8'h4C,4'd10},
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h12,4'd10},
      {2'd0,1'b0,8'hA0,1'b0,3'd0,3'd3,8'h02,4'd7},   // R7 code 5 picks 4 from base 3
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd5,8'h05,4'd7},
      {2'd0,1'b0,8'hE1,1'b0,3'd0,3'd5,8'h02,4'd8},   // R8 code 7 line 1
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h00,4'd8},
      {2'd0,1'b0,8'h40,1'b0,3'd0,3'd5,8'h02,4'd8},   // R8 code 2
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h00,4'd8},
      {2'd0,1'b0,8'h80,1'b0,3'd0,3'd0,8'h00,4'd9},   // R9 code 4 bit7=1
      {2'd2,1'b0,8'h00,1'b1,3'd6,3'd2,8'h4E,4'd10},
      {2'd0,1'b0,8'h0C,1'b0,3'd0,3'd0,8'h00,4'd12},  // R12 arm poll
      {2'd1,1'b0,8'h00,1'b1,3'd6,3'd1,8'h06,4'd12},
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h00,4'd12},
      {2'd1,1'b0,8'h00,1'b0,3'd0,3'd1,8'hA5,4'd12},  // R12 disarmed
      {2'd0,1'b0,8'h0C,1'b0,3'd0,3'd0,8'h00,4'd12},
      {2'd1,1'b0,8'h00,1'b0,3'd0,3'd1,8'h07,4'd12},  // R12 no winner
      {2'd0,1'b0,8'h68,1'b0,3'd0,3'd7,8'h01,4'd6},   // R6 special mask
      {2'd0,1'b0,8'h28,1'b0,3'd0,3'd7,8'h01,4'd6},
      {2'd0,1'b0,8'h48,1'b0,3'd0,3'd7,8'h00,4'd6},
      {2'd0,1'b0,8'h10,1'b0,3'd0,3'd4,8'h00,4'd2},   // R2 restart, no mode word
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd5,8'h00,4'd2},
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd6,8'h00,4'd2},
      {2'd0,1'b1,8'h27,1'b0,3'd0,3'd4,8'h00,4'd3},
      {2'd0,1'b1,8'h00,1'b0,3'd0,3'd4,8'h00,4'd3},
      {2'd0,1'b1,8'h0F,1'b0,3'd0,3'd4,8'h0F,4'd3},   // R3 normal after two words
      {2'd2,1'b0,8'h00,1'b1,3'd2,3'd2,8'h22,4'd10},
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h04,4'd10},
      {2'd0,1'b0,8'h62,1'b0,3'd0,3'd3,8'h00,4'd8},
      {2'd0,1'b0,8'h11,1'b0,3'd0,3'd0,8'h00,4'd2},
      {2'd0,1'b1,8'h08,1'b0,3'd0,3'd0,8'h00,4'd3},
      {2'd0,1'b1,8'h00,1'b0,3'd0,3'd0,8'h00,4'd3},
      {2'd0,1'b1,8'h02,1'b0,3'd0,3'd6,8'h00,4'd4},   // R4 auto EOI on
      {2'd2,1'b0,8'h00,1'b1,3'd2,3'd2,8'h0A,4'd11},
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h00,4'd11},  // R11
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd5,8'h03,4'd11},
      {2'd0,1'b0,8'h00,1'b0,3'd0,3'd0,8'h00,4'd9},   // R9 code 0 bit7=0
      {2'd2,1'b0,8'h00,1'b1,3'd5,3'd2,8'h0D,4'd11},
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd5,8'h03,4'd9},
      {2'd3,1'b0,8'h00,1'b0,3'd0,3'd3,8'h00,4'd11}
   };

   function automatic logic [7:0] observe(input logic [2:0] ck);
      case (ck)
         3'd1: return rdata;
         3'd2: return vector;
         3'd3: return isr;
         3'd4: return imr;
         3'd5: return {5'd0, prio_base};
         3'd6: return {7'd0, spec_nest};
         default: return {7'd0, spec_mask};
      endcase
   endfunction

   task automatic compare(input logic [7:0] got, input logic [7:0] exp, input int rq);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d got %h expected %h", rq, got, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_en = 0; rd_en = 0; ack = 0; win_valid = 0; win_line = 0; addr = 0; wdata = 0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      irr = 8'hA5;
      idle_inputs();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1 reset state
      #5;
      compare(isr, 8'h00, 1);
      compare(imr, 8'h00, 1);
      compare({5'd0, prio_base}, 8'h00, 1);
      compare({6'd0, spec_nest, spec_mask}, 8'h00, 1);
      compare(rdata, 8'hA5, 1);
      compare(vector, 8'h07, 1);

      for (int i = 0; i < N; i++) begin
         logic [1:0] op;
         logic [2:0] ck;
         @(negedge clk);
         op        = TBL[i][29:28];
         addr      = TBL[i][27];
         wdata     = TBL[i][26:19];
         win_valid = TBL[i][18];
         win_line  = TBL[i][17:15];
         ck        = TBL[i][14:12];
         wr_en     = (op == 2'd0);
         rd_en     = (op == 2'd1);
         ack       = (op == 2'd2);
         #5;
         if (ck == 3'd1 || ck == 3'd2) compare(observe(ck), TBL[i][11:4], int'(TBL[i][3:0]));
         @(posedge clk);
         @(negedge clk);
         idle_inputs();
         if (ck > 3'd2) compare(observe(ck), TBL[i][11:4], int'(TBL[i][3:0]));
      end

      // R12 request clear pulse during a poll read
      @(negedge clk);
      wr_en = 1; addr = 0; wdata = 8'h0C;
      @(negedge clk);
      idle_inputs();
      rd_en = 1; win_valid = 1; win_line = 3'd3;
      #5 compare(irr_clr, 8'h08, 12);
      @(negedge clk);
      idle_inputs();
      #5 compare(irr_clr, 8'h00, 12);

      // R1 mask write accepted straight after reset
      rst_n = 0;
      @(negedge clk) rst_n = 1;
      wr_en = 1; addr = 1; wdata = 8'h33;
      @(negedge clk);
      idle_inputs();
      compare(imr, 8'h33, 1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule